// File: doc/BRIEF.md
# Bit-Synchronous Line Receiver with Sync Hunt

This block is the receive half of one synchronous serial line. Serial data arrives as a bit value with a one-cycle strobe, already brought into the core clock domain from the modem's receive clock. While enabled, the receiver first slides bit by bit through the incoming stream looking for a programmable sync pattern. Once framing is established it assembles characters of 6, 8 or 12 bits and hands each one to a 12-bit holding buffer for the host to read.

Captured bits wait in a one-bit holding stage. A line scanner services that stage once every `SCAN_PERIOD` core cycles. A strobe that arrives while an older bit is still waiting is recorded as a bit-level overrun. A finished character that lands while the previous one is still unread is recorded as a character-level overrun. Carrier loss and ring indication are latched beside the framing status. Software writes one control word to configure the line and to clear the sticky flags, and reads the buffer by pulsing a read strobe.

Top module: `srx_line_rx`

## Requirements
- R1: After reset `rx_data` is zero, `done_irq` is low and every bit of `rx_status` is zero except bit 6, which follows `carrier_det`.
- R2: Control bit 0 enables reception. While it is 0, strobes are ignored, no bit overrun is flagged and the sync state (status bits 9:8) is 00. Clearing it returns the hunt to 00.
- R3: With bit 4 clear, the state goes from hunting (00) to synchronized (10) as soon as the last L received bits equal the low L bits of the sync pattern. L is the character length, and the earliest received bit is the most significant.
- R4: With bit 4 set, a first match gives state 01. If the next L bits also match, the state becomes 10. If they do not match, the state returns to 00 and hunting continues. Code 11 never appears.
- R5: Control bits 3:2 select the length: 00 gives 6 bits, 01 gives 8 bits, and 10 or 11 give 12 bits. A character is right-justified in `rx_data[11:0]`, and bits 15:12 read zero.
- R6: Once synchronized, every L bits complete a character. This loads the buffer and sets done (status bit 5). `done_irq` equals done, and a `buf_rd` pulse clears it.
- R7: A character that completes while done is set and no read occurs in that cycle sets the character-overrun flag (bit 13). The new character replaces the buffer contents.
- R8: A strobe that arrives while a captured bit is still waiting for its scanner slot sets the bit-overrun flag (bit 14). The newer bit replaces the waiting one.
- R9: Status bit 6 shows the live `carrier_det`. A falling edge of carrier while reception is enabled sets the carrier-lost flag (bit 12).
- R10: The ring flag (bit 15) is set while `ring_in` is high and control bit 1 (ring enable) is 1. With ring enable at 0 it stays clear.
- R11: Bits 4:0 of the control word read back in the same status positions. Flags 15:12 are cleared by writing 1 to them, and writing 0 leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_strobe | input | 1 | One-cycle pulse marking a received bit |
| rx_bit | input | 1 | Received bit value, valid with `rx_strobe` |
| carrier_det | input | 1 | Carrier-detect level from the modem |
| ring_in | input | 1 | Ring indication level from the modem |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word: bits 4:0 configuration, bits 15:12 write-one-to-clear |
| sync_we | input | 1 | Sync pattern write strobe |
| sync_wdata | input | 12 | Sync pattern value |
| buf_rd | input | 1 | Host read of the buffer, clears done |
| rx_data | output | 16 | Holding buffer, character in bits 11:0 |
| rx_status | output | 16 | Receiver status word |
| done_irq | output | 1 | Character-ready interrupt request |

## Verification
On every cycle the assertions check the following:
- The sync state never takes code 11 and returns to hunting one cycle after the enable is low.
- The upper buffer bits stay zero.
- A completed character raises done, and a plain read drops it.
- The character-overrun and carrier-lost flags follow their triggering events.

Some behaviour needs whole scenarios from the bench:
- Finding the right sync pattern over a stream of bits.
- The single and double sync sequences, including a failed second match.
- The data values assembled at each length.
- Bit overrun under back-to-back strobes.
- Gating of the ring flag.
- The write-one-to-clear behaviour.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    SS_HUNT = 2'b00,
    SS_ONE  = 2'b01,
    SS_LOCK = 2'b10
  } sync_state_e;

  // Character length selected by the two-bit code; 10 and 11 both give 12.
  function automatic int char_len(input logic [1:0] code);
    case (code)
      2'b00:   return 6;
      2'b01:   return 8;
      default: return 12;
    endcase
  endfunction

endpackage

// File: rtl/srx_bit_capture.sv
module srx_bit_capture #(
  parameter int SCAN_PERIOD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic strobe,
  input  logic bit_in,
  output logic bit_valid,
  output logic bit_val,
  output logic ovr_pulse
);

  localparam int CW = (SCAN_PERIOD > 1) ? $clog2(SCAN_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(SCAN_PERIOD - 1);

  logic [CW-1:0] scan_q, scan_d;
  logic          pend_q, pend_d;
  logic          pbit_q, pbit_d;
  logic          ovr_q, ovr_d;
  logic          slot, take;

  assign slot = (scan_q == LAST);
  assign take = slot & pend_q;

  always_comb begin
    scan_d = slot ? '0 : scan_q + 1'b1;
    pend_d = pend_q;
    pbit_d = pbit_q;
    ovr_d  = 1'b0;
    if (take) pend_d = 1'b0;
    if (!enable) begin
      pend_d = 1'b0;
    end else if (strobe) begin
      pend_d = 1'b1;
      pbit_d = bit_in;
      ovr_d  = pend_q & ~slot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_q <= '0;
      pend_q <= 1'b0;
      pbit_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      scan_q <= scan_d;
      pend_q <= pend_d;
      pbit_q <= pbit_d;
      ovr_q  <= ovr_d;
    end
  end

  assign bit_valid = take;
  assign bit_val   = pbit_q;
  assign ovr_pulse = ovr_q;

endmodule

// File: rtl/srx_framer.sv
module srx_framer import srx_pkg::*; #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        len_code,
  input  logic              two_sync,
  input  logic [DATA_W-1:0] sync_pat,
  input  logic              bit_valid,
  input  logic              bit_val,
  output sync_state_e       state_o,
  output logic              char_done_o,
  output logic [DATA_W-1:0] char_o
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  sync_state_e       st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, last_idx;
  logic [DATA_W-1:0] sh_q, sh_d, sh_new, mask;
  logic [DATA_W-1:0] char_q, char_d;
  logic              cdone_q, cdone_d;
  logic              match, full;

  always_comb begin
    last_idx = CNT_W'(char_len(len_code) - 1);
    for (int i = 0; i < DATA_W; i++) begin
      mask[i] = (CNT_W'(i) <= last_idx);
    end
  end

  assign sh_new = {sh_q[DATA_W-2:0], bit_val};
  assign match  = ((sh_new ^ sync_pat) & mask) == '0;
  assign full   = (cnt_q >= last_idx);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    char_d  = char_q;
    cdone_d = 1'b0;
    if (!enable) begin
      st_d  = SS_HUNT;
      cnt_d = '0;
      sh_d  = '0;
    end else if (bit_valid) begin
      sh_d = sh_new;
      case (st_q)
        SS_HUNT: begin
          if (full && match) begin
            st_d  = two_sync ? SS_ONE : SS_LOCK;
            cnt_d = '0;
          end else if (!full) begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        SS_ONE: begin
          if (full) begin
            // A failed second match keeps sliding: the window is already full.
            st_d  = match ? SS_LOCK : SS_HUNT;
            cnt_d = match ? '0 : last_idx;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        SS_LOCK: begin
          if (full) begin
            cdone_d = 1'b1;
            char_d  = sh_new & mask;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          st_d  = SS_HUNT;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SS_HUNT;
      cnt_q   <= '0;
      sh_q    <= '0;
      char_q  <= '0;
      cdone_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      char_q  <= char_d;
      cdone_q <= cdone_d;
    end
  end

  assign state_o     = st_q;
  assign char_done_o = cdone_q;
  assign char_o      = char_q;

endmodule

// File: rtl/srx_status_regs.sv
module srx_status_regs import srx_pkg::*; #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [REG_W-1:0]  ctl_wdata,
  input  logic              sync_we,
  input  logic [DATA_W-1:0] sync_wdata,
  input  logic              buf_rd,
  input  logic              char_done,
  input  logic [DATA_W-1:0] char_in,
  input  logic              bit_ovr,
  input  logic              carrier_det,
  input  logic              ring_in,
  input  sync_state_e       sync_state,
  output logic              rcv_en,
  output logic [1:0]        len_code,
  output logic              two_sync,
  output logic [DATA_W-1:0] sync_pat,
  output logic [REG_W-1:0]  status,
  output logic [REG_W-1:0]  rx_data,
  output logic              done
);

  logic              en_q, ren_q, two_q;
  logic [1:0]        len_q;
  logic [DATA_W-1:0] sync_q, buf_q;
  logic              done_q, done_d;
  logic              car_q;
  logic              f_cl_q, f_co_q, f_bo_q, f_rg_q;
  logic              f_cl_d, f_co_d, f_bo_d, f_rg_d;
  logic [3:0]        w1c;

  assign w1c = ctl_we ? ctl_wdata[15:12] : 4'b0000;

  always_comb begin
    done_d = done_q;
    if (buf_rd) done_d = 1'b0;
    if (char_done) done_d = 1'b1;
    f_cl_d = (f_cl_q & ~w1c[0]) | (en_q & car_q & ~carrier_det);
    f_co_d = (f_co_q & ~w1c[1]) | (char_done & done_q & ~buf_rd);
    f_bo_d = (f_bo_q & ~w1c[2]) | bit_ovr;
    f_rg_d = (f_rg_q & ~w1c[3]) | (ring_in & ren_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ren_q <= 1'b0;
      len_q <= 2'b00;
      two_q <= 1'b0;
    end else if (ctl_we) begin
      en_q  <= ctl_wdata[0];
      ren_q <= ctl_wdata[1];
      len_q <= ctl_wdata[3:2];
      two_q <= ctl_wdata[4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else if (sync_we) sync_q <= sync_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_q <= '0;
    else if (char_done) buf_q <= char_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      car_q  <= 1'b0;
      f_cl_q <= 1'b0;
      f_co_q <= 1'b0;
      f_bo_q <= 1'b0;
      f_rg_q <= 1'b0;
    end else begin
      done_q <= done_d;
      car_q  <= carrier_det;
      f_cl_q <= f_cl_d;
      f_co_q <= f_co_d;
      f_bo_q <= f_bo_d;
      f_rg_q <= f_rg_d;
    end
  end

  assign status = {f_rg_q, f_bo_q, f_co_q, f_cl_q, 2'b00, sync_state,
                   1'b0, carrier_det, done_q, two_q, len_q, ren_q, en_q};
  assign rx_data  = {{(REG_W-DATA_W){1'b0}}, buf_q};
  assign rcv_en   = en_q;
  assign len_code = len_q;
  assign two_sync = two_q;
  assign sync_pat = sync_q;
  assign done     = done_q;

endmodule

// File: rtl/srx_line_rx.sv
module srx_line_rx import srx_pkg::*; #(
  parameter int DATA_W      = 12,
  parameter int SCAN_PERIOD = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_strobe,
  input  logic              rx_bit,
  input  logic              carrier_det,
  input  logic              ring_in,
  input  logic              ctl_we,
  input  logic [REG_W-1:0]  ctl_wdata,
  input  logic              sync_we,
  input  logic [DATA_W-1:0] sync_wdata,
  input  logic              buf_rd,
  output logic [REG_W-1:0]  rx_data,
  output logic [REG_W-1:0]  rx_status,
  output logic              done_irq
);

  logic              rcv_en, two_sync;
  logic [1:0]        len_code;
  logic [DATA_W-1:0] sync_pat, fr_char;
  logic              cap_valid, cap_bit, cap_ovr;
  logic              fr_char_done;
  sync_state_e       fr_state;

  srx_bit_capture #(.SCAN_PERIOD(SCAN_PERIOD)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (rcv_en),
    .strobe    (rx_strobe),
    .bit_in    (rx_bit),
    .bit_valid (cap_valid),
    .bit_val   (cap_bit),
    .ovr_pulse (cap_ovr)
  );

  srx_framer #(.DATA_W(DATA_W)) u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (rcv_en),
    .len_code    (len_code),
    .two_sync    (two_sync),
    .sync_pat    (sync_pat),
    .bit_valid   (cap_valid),
    .bit_val     (cap_bit),
    .state_o     (fr_state),
    .char_done_o (fr_char_done),
    .char_o      (fr_char)
  );

  srx_status_regs #(.DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_we      (ctl_we),
    .ctl_wdata   (ctl_wdata),
    .sync_we     (sync_we),
    .sync_wdata  (sync_wdata),
    .buf_rd      (buf_rd),
    .char_done   (fr_char_done),
    .char_in     (fr_char),
    .bit_ovr     (cap_ovr),
    .carrier_det (carrier_det),
    .ring_in     (ring_in),
    .sync_state  (fr_state),
    .rcv_en      (rcv_en),
    .len_code    (len_code),
    .two_sync    (two_sync),
    .sync_pat    (sync_pat),
    .status      (rx_status),
    .rx_data     (rx_data),
    .done        (done_irq)
  );

endmodule

// File: rtl/srx_line_rx_chk.sv
module srx_line_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        buf_rd,
  input logic        carrier_det,
  input logic        fr_char_done,
  input logic        done_irq,
  input logic [15:0] rx_status,
  input logic [15:0] rx_data
);

  assert_state_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_status[9:8] != 2'b11);

  assert_disable_hunts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_status[0] |=> rx_status[9:8] == 2'b00);

  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_data[15:12] == 4'h0);

  assert_done_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fr_char_done |=> done_irq);

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd && !fr_char_done) |=> !done_irq);

  assert_char_ovr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_char_done && done_irq && !buf_rd) |=> rx_status[13]);

  assert_carrier_lost_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_status[0] && $fell(carrier_det)) |=> rx_status[12]);

endmodule

bind srx_line_rx srx_line_rx_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .buf_rd       (buf_rd),
  .carrier_det  (carrier_det),
  .fr_char_done (fr_char_done),
  .done_irq     (done_irq),
  .rx_status    (rx_status),
  .rx_data      (rx_data)
);

// File: tb/srx_line_rx_tb.sv
`timescale 1ns/1ps
module srx_line_rx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_strobe = 1'b0, rx_bit = 1'b0;
  logic        carrier_det = 1'b0, ring_in = 1'b0;
  logic        ctl_we = 1'b0, sync_we = 1'b0, buf_rd = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [11:0] sync_wdata = '0;
  logic [15:0] rx_data, rx_status;
  logic        done_irq;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  srx_line_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rx_strobe(rx_strobe), .rx_bit(rx_bit),
    .carrier_det(carrier_det), .ring_in(ring_in), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .sync_we(sync_we), .sync_wdata(sync_wdata),
    .buf_rd(buf_rd), .rx_data(rx_data), .rx_status(rx_status),
    .done_irq(done_irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [15:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
    idle(2);
  endtask

  task automatic wr_sync(input logic [11:0] v);
    @(negedge clk); sync_we = 1'b1; sync_wdata = v;
    @(negedge clk); sync_we = 1'b0;
  endtask

  task automatic rd_buf();
    @(negedge clk); buf_rd = 1'b1;
    @(negedge clk); buf_rd = 1'b0;
    idle(1);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rx_strobe = 1'b1; rx_bit = b;
    @(negedge clk); rx_strobe = 1'b0;
    idle(6);
  endtask

  task automatic send_word(input logic [11:0] v, input int len);
    for (int i = len - 1; i >= 0; i--) send_bit(v[i]);
    idle(3);
  endtask

  task automatic burst3();
    @(negedge clk); rx_strobe = 1'b1; rx_bit = 1'b1;
    idle(3);
    rx_strobe = 1'b0;
    idle(4);
  endtask

  task automatic t_reset();
    check("R1 status", rx_status, 16'h0000);
    check("R1 data", rx_data, 16'h0000);
    check("R1 irq", {15'b0, done_irq}, 16'h0000);
  endtask

  task automatic t_len8_single();
    wr_sync(12'h096);
    wr_ctl(16'h0005);
    check("R11 readback", rx_status, 16'h0005);
    send_word(12'h000, 3);
    send_word(12'h096, 8);
    check("R3 locked", {14'b0, rx_status[9:8]}, 16'h0002);
    send_word(12'h03C, 8);
    check("R6 data8", rx_data, 16'h003C);
    check("R6 irq", {15'b0, done_irq}, 16'h0001);
    check("R6 done bit", {15'b0, rx_status[5]}, 16'h0001);
    rd_buf();
    check("R6 read clears", {15'b0, done_irq}, 16'h0000);
  endtask

  task automatic t_len6();
    wr_ctl(16'h0000);
    wr_sync(12'h02D);
    wr_ctl(16'h0001);
    send_word(12'h000, 2);
    send_word(12'h02D, 6);
    check("R3 locked6", {14'b0, rx_status[9:8]}, 16'h0002);
    send_word(12'h015, 6);
    check("R5 data6", rx_data, 16'h0015);
    rd_buf();
  endtask

  task automatic t_len12();
    wr_ctl(16'h0000);
    wr_sync(12'hA5C);
    wr_ctl(16'h0009);
    send_word(12'h000, 2);
    send_word(12'hA5C, 12);
    send_word(12'hF0F, 12);
    check("R5 data12", rx_data, 16'h0F0F);
    rd_buf();
  endtask

  task automatic t_two_sync();
    wr_ctl(16'h0000);
    wr_sync(12'h096);
    wr_ctl(16'h0015);
    send_word(12'h000, 3);
    send_word(12'h096, 8);
    check("R4 one seen", {14'b0, rx_status[9:8]}, 16'h0001);
    send_word(12'h096, 8);
    check("R4 locked", {14'b0, rx_status[9:8]}, 16'h0002);
    send_word(12'h05A, 8);
    check("R4 data", rx_data, 16'h005A);
    rd_buf();
    wr_ctl(16'h0000);
    wr_ctl(16'h0015);
    send_word(12'h000, 3);
    send_word(12'h096, 8);
    check("R4 one seen again", {14'b0, rx_status[9:8]}, 16'h0001);
    send_word(12'h000, 8);
    check("R4 mismatch hunts", {14'b0, rx_status[9:8]}, 16'h0000);
  endtask

  task automatic t_char_ovr();
    wr_ctl(16'h0000);
    wr_ctl(16'h0005);
    send_word(12'h000, 3);
    send_word(12'h096, 8);
    send_word(12'h011, 8);
    send_word(12'h022, 8);
    check("R7 flag", {15'b0, rx_status[13]}, 16'h0001);
    check("R7 overwrite", rx_data, 16'h0022);
    wr_ctl(16'h0005);
    check("R11 zero keeps flag", {15'b0, rx_status[13]}, 16'h0001);
    wr_ctl(16'h2005);
    check("R11 w1c clears", {15'b0, rx_status[13]}, 16'h0000);
    rd_buf();
  endtask

  task automatic t_bit_ovr();
    burst3();
    check("R8 flag", {15'b0, rx_status[14]}, 16'h0001);
    wr_ctl(16'h4005);
    check("R8 cleared", {15'b0, rx_status[14]}, 16'h0000);
  endtask

  task automatic t_disable();
    wr_ctl(16'h0000);
    check("R2 hunt on disable", rx_status, 16'h0000);
    burst3();
    check("R2 ignored strobes", rx_status, 16'h0000);
  endtask

  task automatic t_carrier();
    wr_ctl(16'h0001);
    @(negedge clk); carrier_det = 1'b1;
    idle(2);
    check("R9 live", {15'b0, rx_status[6]}, 16'h0001);
    carrier_det = 1'b0;
    idle(2);
    check("R9 lost", {15'b0, rx_status[12]}, 16'h0001);
    wr_ctl(16'h1000);
    carrier_det = 1'b1;
    idle(2);
    carrier_det = 1'b0;
    idle(2);
    check("R9 no flag disabled", {15'b0, rx_status[12]}, 16'h0000);
  endtask

  task automatic t_ring();
    @(negedge clk); ring_in = 1'b1;
    idle(3);
    check("R10 gated", {15'b0, rx_status[15]}, 16'h0000);
    wr_ctl(16'h0002);
    check("R10 set", {15'b0, rx_status[15]}, 16'h0001);
    @(negedge clk); ring_in = 1'b0;
    wr_ctl(16'h8002);
    check("R10 cleared", {15'b0, rx_status[15]}, 16'h0000);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    t_reset();
    t_len8_single();
    t_len6();
    t_len12();
    t_two_sync();
    t_char_ovr();
    t_bit_ovr();
    t_disable();
    t_carrier();
    t_ring();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule